// File: doc/BRIEF.md
# USB Upstream Port Force and Activity Register

This block is the control and status register for a single upstream USB port. Firmware writes a 3-bit force code that can override the D+ and D- line drivers. Each line can be driven high, driven low, or released to high impedance. When the code is zero, the serial engine's own drive-enable and drive-value signals pass straight through to the pads.

The same byte also holds a sticky bus-activity flag. The flag is set by hardware whenever the synchronized line state differs from the idle J state. Software can clear the flag but never set it. The byte also reports the live, synchronized levels of the two lines. Two further read/write bits, an endpoint mode bit and an endpoint size bit, are held here and driven out to the endpoint logic.

Reads are combinational from the held state. A write takes effect at the clock edge on which the write strobe is sampled high. The line inputs pass through a synchronizer of `SYNC_STAGES` flops (default 2) before they are used. The idle J state is D+ high and D- low, set by the parameter `IDLE_DP`.

Top module: `usb_port_force_reg`

## Requirements
- R1: After reset the force code reads 000, the activity flag reads 0, bits 7:6 read 0, and with the lines idle (D+ high, D- low) the read byte is 8'h20.
- R2: With force code 000 (bits 2:0), each pad drive-enable and drive-value output equals the corresponding serial-engine input in the same cycle.
- R3: Code 001 drives D+ high and D- low. Code 010 drives D+ low and D- high. Both lines are enabled for both codes.
- R4: Codes 011 and 100 each enable both drivers with both values low.
- R5: Code 101 releases D+ (enable 0) and drives D- low. Code 110 drives D+ low and releases D-. Code 111 releases both lines. A released line's value output is 0.
- R6: A line state other than J, once it has been seen at the output of the synchronizer for one cycle, sets bit 3. The flag reads 1 after SYNC_STAGES+1 rising edges from the input change, and still reads 0 after SYNC_STAGES edges. An idle J line never sets the flag.
- R7: Writing a 0 to bit 3 clears the flag, provided no activity is seen in that cycle. Writing a 1 to bit 3 leaves the flag at 1.
- R8: When a clearing write and an activity detection fall in the same cycle, the flag ends up set.
- R9: Bit 5 reads the synchronized D+ level and bit 4 reads the synchronized D- level (1 = high). Both follow the pins after SYNC_STAGES rising edges.
- R10: Bits 7 (endpoint size) and 6 (endpoint mode) are read/write. They appear on the ep_size and ep_mode outputs after the write edge.
- R11: Writing 1 to bit 3 while the flag is 0 leaves it at 0; software cannot set the flag.
- R12: Bits 2:0 read back the last force code written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| line_dp | input | 1 | D+ pin level |
| line_dm | input | 1 | D- pin level |
| sie_dp_oe | input | 1 | Serial engine D+ drive enable |
| sie_dp_out | input | 1 | Serial engine D+ drive value |
| sie_dm_oe | input | 1 | Serial engine D- drive enable |
| sie_dm_out | input | 1 | Serial engine D- drive value |
| pad_dp_oe | output | 1 | D+ pad drive enable |
| pad_dp_out | output | 1 | D+ pad drive value |
| pad_dm_oe | output | 1 | D- pad drive enable |
| pad_dm_out | output | 1 | D- pad drive value |
| ep_mode | output | 1 | Endpoint mode configuration bit |
| ep_size | output | 1 | Endpoint size configuration bit |

## Verification
The activity flag has a hardware set and a software clear that can land on the same clock edge. The bench provokes this by holding the lines in a non-J state so that detection repeats every cycle. It then issues a write with bit 3 at 0 and requires the flag to still read 1 afterwards. It then returns the lines to J, waits for the synchronizer to drain, and repeats the same write, which must now clear the flag. That second step proves the earlier result came from the collision and not from a broken clear.

// File: rtl/usbpf_pkg.sv
package usbpf_pkg;

    localparam int REG_W     = 8;
    localparam int FORCE_W   = 3;
    localparam int ACT_BIT   = 3;
    localparam int DM_BIT    = 4;
    localparam int DP_BIT    = 5;
    localparam int MODE_BIT  = 6;
    localparam int SIZE_BIT  = 7;

    typedef enum logic [FORCE_W-1:0] {
        FRC_NONE = 3'd0,
        FRC_J    = 3'd1,
        FRC_K    = 3'd2,
        FRC_SE0  = 3'd3,
        FRC_LOW  = 3'd4,
        FRC_DPZ  = 3'd5,
        FRC_DMZ  = 3'd6,
        FRC_ALLZ = 3'd7
    } force_code_e;

    typedef struct packed {
        logic oe;
        logic val;
    } drv_t;

    typedef struct packed {
        force_code_e code;
        logic        ep_mode;
        logic        ep_size;
    } ctrl_t;

endpackage

// File: rtl/usbpf_line_sync.sv
module usbpf_line_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/usbpf_activity.sv
module usbpf_activity #(
    parameter bit IDLE_DP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dp_s,
    input  logic dm_s,
    input  logic clr_req,
    output logic flag
);
    logic non_idle;
    logic flag_d, flag_q;

    assign non_idle = !((dp_s == IDLE_DP) && (dm_s == !IDLE_DP));

    always_comb begin
        flag_d = flag_q;
        if (clr_req)  flag_d = 1'b0;
        if (non_idle) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R6
    act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        non_idle |=> flag_q);

    // R7
    act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !non_idle) |=> !flag_q);

    // R11
    act_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !non_idle) |=> !flag_q);

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);
endmodule

// File: rtl/usbpf_force_decode.sv
module usbpf_force_decode
    import usbpf_pkg::*;
(
    input  force_code_e code,
    input  drv_t        sie_dp,
    input  drv_t        sie_dm,
    output drv_t        pad_dp,
    output drv_t        pad_dm
);
    localparam drv_t D_HI = '{oe: 1'b1, val: 1'b1};
    localparam drv_t D_LO = '{oe: 1'b1, val: 1'b0};
    localparam drv_t D_Z  = '{oe: 1'b0, val: 1'b0};

    always_comb begin
        unique case (code)
            FRC_NONE: begin pad_dp = sie_dp; pad_dm = sie_dm; end
            FRC_J:    begin pad_dp = D_HI;   pad_dm = D_LO;   end
            FRC_K:    begin pad_dp = D_LO;   pad_dm = D_HI;   end
            FRC_SE0:  begin pad_dp = D_LO;   pad_dm = D_LO;   end
            FRC_LOW:  begin pad_dp = D_LO;   pad_dm = D_LO;   end
            FRC_DPZ:  begin pad_dp = D_Z;    pad_dm = D_LO;   end
            FRC_DMZ:  begin pad_dp = D_LO;   pad_dm = D_Z;    end
            default:  begin pad_dp = D_Z;    pad_dm = D_Z;    end
        endcase
    end
endmodule

// File: rtl/usb_port_force_reg.sv
module usb_port_force_reg
    import usbpf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit IDLE_DP     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             line_dp,
    input  logic             line_dm,
    input  logic             sie_dp_oe,
    input  logic             sie_dp_out,
    input  logic             sie_dm_oe,
    input  logic             sie_dm_out,
    output logic             pad_dp_oe,
    output logic             pad_dp_out,
    output logic             pad_dm_oe,
    output logic             pad_dm_out,
    output logic             ep_mode,
    output logic             ep_size
);
    ctrl_t ctrl_d, ctrl_q;
    logic  dp_s, dm_s, act_flag, clr_req;
    drv_t  pad_dp, pad_dm;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr) begin
            ctrl_d.code    = force_code_e'(reg_wdata[FORCE_W-1:0]);
            ctrl_d.ep_mode = reg_wdata[MODE_BIT];
            ctrl_d.ep_size = reg_wdata[SIZE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{code: FRC_NONE, ep_mode: 1'b0, ep_size: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign clr_req = reg_wr && !reg_wdata[ACT_BIT];

    usbpf_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_DP)) u_sync_dp (
        .clk(clk), .rst_n(rst_n), .din(line_dp), .dout(dp_s));

    usbpf_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(!IDLE_DP)) u_sync_dm (
        .clk(clk), .rst_n(rst_n), .din(line_dm), .dout(dm_s));

    usbpf_activity #(.IDLE_DP(IDLE_DP)) u_activity (
        .clk(clk), .rst_n(rst_n), .dp_s(dp_s), .dm_s(dm_s),
        .clr_req(clr_req), .flag(act_flag));

    usbpf_force_decode u_decode (
        .code  (ctrl_q.code),
        .sie_dp('{oe: sie_dp_oe, val: sie_dp_out}),
        .sie_dm('{oe: sie_dm_oe, val: sie_dm_out}),
        .pad_dp(pad_dp),
        .pad_dm(pad_dm));

    assign pad_dp_oe  = pad_dp.oe;
    assign pad_dp_out = pad_dp.val;
    assign pad_dm_oe  = pad_dm.oe;
    assign pad_dm_out = pad_dm.val;
    assign ep_mode    = ctrl_q.ep_mode;
    assign ep_size    = ctrl_q.ep_size;

    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[FORCE_W-1:0]          = ctrl_q.code;
        reg_rdata[ACT_BIT]              = act_flag;
        reg_rdata[DM_BIT]               = dm_s;
        reg_rdata[DP_BIT]               = dp_s;
        reg_rdata[MODE_BIT]             = ctrl_q.ep_mode;
        reg_rdata[SIZE_BIT]             = ctrl_q.ep_size;
    end

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2:0] == 3'd0) |->
            (pad_dp_oe == sie_dp_oe && pad_dp_out == sie_dp_out &&
             pad_dm_oe == sie_dm_oe && pad_dm_out == sie_dm_out));

    // R5
    all_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2:0] == 3'd7) |-> (!pad_dp_oe && !pad_dm_oe));

    // R10
    ep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (ep_size == $past(reg_wdata[SIZE_BIT]) &&
                    ep_mode == $past(reg_wdata[MODE_BIT])));

    // R12
    code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[2:0] == $past(reg_wdata[2:0])));

    // R10
    ep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(ep_size) && $stable(ep_mode)));
endmodule

// File: tb/usb_port_force_reg_bench.sv
module usb_port_force_reg_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       line_dp = 1'b1, line_dm = 1'b0;
    logic       sie_dp_oe = 1'b0, sie_dp_out = 1'b0, sie_dm_oe = 1'b0, sie_dm_out = 1'b0;
    logic       pad_dp_oe, pad_dp_out, pad_dm_oe, pad_dm_out, ep_mode, ep_size;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    usb_port_force_reg #(.SYNC_STAGES(SYNC)) u_usb_port_force_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .line_dp(line_dp), .line_dm(line_dm),
        .sie_dp_oe(sie_dp_oe), .sie_dp_out(sie_dp_out),
        .sie_dm_oe(sie_dm_oe), .sie_dm_out(sie_dm_out),
        .pad_dp_oe(pad_dp_oe), .pad_dp_out(pad_dp_out),
        .pad_dm_oe(pad_dm_oe), .pad_dm_out(pad_dm_out),
        .ep_mode(ep_mode), .ep_size(ep_size));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [3:0] pads();
        return {pad_dp_oe, pad_dp_out, pad_dm_oe, pad_dm_out};
    endfunction

    // expected {dp_oe,dp_val,dm_oe,dm_val} per requirement R3..R5
    function automatic logic [3:0] exp_pads(input logic [2:0] c);
        case (c)
            3'd1: return 4'b1110;
            3'd2: return 4'b1011;
            3'd3: return 4'b1010;
            3'd4: return 4'b1010;
            3'd5: return 4'b0010;
            3'd6: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 reset read", reg_rdata, 8'h20);
        chk("R1 reset ep", {6'd0, ep_size, ep_mode}, 8'd0);
    endtask

    task automatic t_passthrough();
        for (int p = 0; p < 16; p += 5) begin
            {sie_dp_oe, sie_dp_out, sie_dm_oe, sie_dm_out} = 4'(p);
            #1;
            chk("R2 passthrough", {4'd0, pads()}, 8'(p));
        end
    endtask

    task automatic t_force_codes();
        for (int c = 1; c < 8; c++) begin
            {sie_dp_oe, sie_dp_out, sie_dm_oe, sie_dm_out} = 4'b0101;
            write_reg(8'(c));
            chk(c < 3 ? "R3 force drive" : (c < 5 ? "R4 force low" : "R5 force release"),
                {4'd0, pads()}, {4'd0, exp_pads(3'(c))});
            chk("R12 code readback", {5'd0, reg_rdata[2:0]}, 8'(c));
        end
        write_reg(8'h08);
        chk("R2 back to none", {4'd0, pads()}, 8'h05);
    endtask

    task automatic t_activity_timing();
        write_reg(8'h00);
        chk("R6 idle stays clear", {7'd0, reg_rdata[3]}, 8'd0);
        line_dp = 1'b0; line_dm = 1'b1;
        cycles(SYNC);
        chk("R9 lines after sync", {6'd0, reg_rdata[5:4]}, 8'b01);
        chk("R6 not yet set", {7'd0, reg_rdata[3]}, 8'd0);
        cycles(1);
        chk("R6 set after sync+1", {7'd0, reg_rdata[3]}, 8'd1);
        line_dp = 1'b0; line_dm = 1'b0;
        cycles(SYNC);
        chk("R9 se0 lines", {6'd0, reg_rdata[5:4]}, 8'b00);
        line_dp = 1'b1; line_dm = 1'b0;
        cycles(SYNC + 1);
        chk("R9 idle lines", {6'd0, reg_rdata[5:4]}, 8'b10);
    endtask

    task automatic t_clear_keep();
        write_reg(8'h08);
        chk("R7 write 1 keeps", {7'd0, reg_rdata[3]}, 8'd1);
        write_reg(8'h00);
        chk("R7 write 0 clears", {7'd0, reg_rdata[3]}, 8'd0);
        write_reg(8'h08);
        chk("R11 sw cannot set", {7'd0, reg_rdata[3]}, 8'd0);
    endtask

    task automatic t_set_wins();
        line_dp = 1'b0; line_dm = 1'b0;
        cycles(SYNC + 1);
        write_reg(8'h00);
        chk("R8 set beats clear", {7'd0, reg_rdata[3]}, 8'd1);
        line_dp = 1'b1; line_dm = 1'b0;
        cycles(SYNC + 1);
        write_reg(8'h00);
        chk("R8 clear after idle", {7'd0, reg_rdata[3]}, 8'd0);
    endtask

    task automatic t_ep_bits();
        write_reg(8'h80);
        chk("R10 size bit", {ep_size, ep_mode, 4'd0, reg_rdata[7:6]}, 8'b1000_0010);
        write_reg(8'h40);
        chk("R10 mode bit", {ep_size, ep_mode, 4'd0, reg_rdata[7:6]}, 8'b0100_0001);
        cycles(3);
        chk("R10 held", {6'd0, ep_size, ep_mode}, 8'b01);
        write_reg(8'h00);
        chk("R10 cleared", {6'd0, ep_size, ep_mode}, 8'b00);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_force_codes();
        t_activity_timing();
        t_clear_keep();
        t_set_wins();
        t_ep_bits();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(20000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule